// File: doc/BRIEF.md
# Watchdog and Brownout Reset Supervisor

This block generates the reset for a processor from two sources. The first is a supply-good flag that an external comparator has already digitised. The second is a watchdog that the processor must service by toggling a kick line. Whenever the supply is bad, the block asserts reset at once. When the supply returns, reset is held for a programmable number of clock ticks and then released. If the running software stops toggling the kick line, the watchdog runs out and the block issues a reset pulse of the same programmable length.

The watchdog has two modes, chosen by a mode line. Normal mode times out after the base period. Extended mode times out after 500 times the base period. In extended mode a "kick line floating" flag makes the block kick itself at 94% of the timeout, which switches the watchdog off in practice. A base period of zero disables the watchdog in both modes. The kick and mode lines are asynchronous, so each passes through a two-flop synchroniser before its edges are detected. The block comes out of its initial state with reset asserted.

Top module: `reset_supervisor`

## Requirements
- R1: While `supplyOk` is low, `rstN` is low in the same cycle. It does not wait for a clock edge.
- R2: After `supplyOk` rises, `rstN` stays low for exactly `holdTicks` clock cycles and then goes high. A `holdTicks` of 0 acts as 1.
- R3: When the watchdog expires, the block produces a reset pulse of exactly `holdTicks` cycles. `wdExpire` is high for one cycle, in the first cycle of that pulse.
- R4: The watchdog count is held at zero while reset is asserted and restarts from zero on release. With no kicks, `rstN` therefore stays high for exactly one timeout.
- R5: A rising or a falling edge on `kickIn` restarts the watchdog count. The edge is seen after a two-flop synchroniser plus one edge-detect flop. Toggling `kickIn` more often than the timeout keeps `rstN` high.
- R6: Any change in the level of `modeSel` restarts the watchdog count.
- R7: `modeSel` = 0 selects normal mode, with a timeout of `basePeriod` cycles. `modeSel` = 1 selects extended mode, with a timeout of 500 × `basePeriod` cycles.
- R8: In extended mode with `kickFloat` = 1, the block kicks itself when the count reaches 94% of the timeout, so the watchdog never expires.
- R9: In normal mode `kickFloat` is ignored. A watchdog that receives no kicks produces reset pulses again and again.
- R10: When `basePeriod` = 0, the watchdog never expires and `wdExpire` never rises.
- R11: `rstP` is always the logical inverse of `rstN`.
- R12: From the block's initial state, reset is asserted. With `supplyOk` high from the start, `rstN` is low for the first `holdTicks` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| supplyOk | input | 1 | Digitised supply-above-threshold flag, high = good |
| kickIn | input | 1 | Watchdog kick line, asynchronous; either edge restarts the count |
| modeSel | input | 1 | Watchdog mode: 0 = normal, 1 = extended (×500) |
| kickFloat | input | 1 | High when the kick line is floating or three-stated |
| holdTicks | input | HOLD_W | Reset hold length in clock cycles |
| basePeriod | input | BASE_W | Base watchdog timeout in clock cycles; 0 disables the watchdog |
| rstN | output | 1 | Active-low reset |
| rstP | output | 1 | Active-high reset |
| wdExpire | output | 1 | One-cycle flag marking a watchdog timeout |

## Verification
Two restart sources can reach the counter in the same cycle as the timeout compare. The first is a mode edge, which also changes the timeout limit for a cycle or two through the synchroniser. The second is a brownout, which can arrive while a watchdog pulse is pending. The bench provokes the first case by pulsing `modeSel` low and back high ten cycles before an extended timeout. For a cycle or two that makes the normal limit visible, far below the running count. The bench then requires that no reset appears for at least 1900 further cycles and that one does appear within 300 cycles after that, so a premature expiry in that window is caught. The bench judges the brownout case through the immediate drop of `rstN` and the exact hold count after recovery.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} supState_t;

  // Strobes from the control to the watchdog datapath.
  typedef struct packed {
    logic wdClr;   // hold watchdog count at zero
    logic wdRun;   // watchdog allowed to count
  } wdStrobe_t;
endpackage

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              supplyOk,
  input  logic [HOLD_W-1:0] holdTicks,
  input  logic              expireHit,
  output wdStrobe_t         strobes,
  output logic              rstActive,
  output logic              wdExpire
);
  localparam int HW1 = HOLD_W + 1;

  supState_t         state   = ST_HOLD;
  logic [HOLD_W-1:0] holdCnt = '0;
  logic              expireQ = 1'b0;
  logic              holdDone;

  // Release on the last hold tick; a zero hold acts as one tick.
  assign holdDone = (HW1'(holdCnt) + HW1'(1)) >= HW1'(holdTicks);

  always_ff @(posedge clk) begin
    expireQ <= 1'b0;
    case (state)
      ST_HOLD: begin
        if (!supplyOk) begin
          holdCnt <= '0;
        end else if (holdDone) begin
          state   <= ST_RUN;
          holdCnt <= '0;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
      default: begin
        holdCnt <= '0;
        if (!supplyOk) begin
          state <= ST_HOLD;
        end else if (expireHit) begin
          state   <= ST_HOLD;
          expireQ <= 1'b1;
        end
      end
    endcase
  end

  assign rstActive     = (state != ST_RUN) || !supplyOk;
  assign strobes.wdClr = rstActive;
  assign strobes.wdRun = !rstActive;
  assign wdExpire      = expireQ;
endmodule

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int BASE_W   = 16,
  parameter int EXT_MULT = 500,
  parameter int SELF_NUM = 470,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              kickIn,
  input  logic              modeSel,
  input  logic              kickFloat,
  input  logic [BASE_W-1:0] basePeriod,
  input  wdStrobe_t         strobes,
  output logic              expireHit
);
  localparam int CNT_W = BASE_W + $clog2(EXT_MULT);
  localparam int N_IN  = 2;   // bit 0: kick line, bit 1: mode line

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncOut;
  logic [N_IN-1:0] prevQ = '0;
  logic [N_IN-1:0] edgeSeen;

  assign rawIn = {modeSel, kickIn};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    logic [SYNC_N-1:0] stages = '0;
    always_ff @(posedge clk) stages <= {stages[SYNC_N-2:0], rawIn[g]};
    assign syncOut[g] = stages[SYNC_N-1];
  end

  always_ff @(posedge clk) prevQ <= syncOut;
  assign edgeSeen = syncOut ^ prevQ;

  logic             modeExt;
  logic             wdOff;
  logic             selfKick;
  logic             kickClr;
  logic [CNT_W-1:0] baseWide;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] selfThr;
  logic [CNT_W-1:0] wdCnt = '0;

  assign modeExt  = syncOut[1];
  assign wdOff    = (basePeriod == '0);
  assign baseWide = CNT_W'(basePeriod);
  assign limit    = modeExt ? baseWide * CNT_W'(EXT_MULT) : baseWide;
  assign selfThr  = baseWide * CNT_W'(SELF_NUM);
  assign selfKick = modeExt && kickFloat && !wdOff && (wdCnt >= selfThr - 1'b1);
  assign kickClr  = (|edgeSeen) || selfKick;
  assign expireHit = strobes.wdRun && !wdOff && !kickClr && (wdCnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (strobes.wdClr || wdOff || kickClr) wdCnt <= '0;
    else if (strobes.wdRun)                wdCnt <= wdCnt + 1'b1;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import sup_pkg::*;
#(
  parameter int HOLD_W   = 16,
  parameter int BASE_W   = 16,
  parameter int EXT_MULT = 500,
  parameter int SELF_NUM = 470
) (
  input  logic              clk,
  input  logic              supplyOk,
  input  logic              kickIn,
  input  logic              modeSel,
  input  logic              kickFloat,
  input  logic [HOLD_W-1:0] holdTicks,
  input  logic [BASE_W-1:0] basePeriod,
  output logic              rstN,
  output logic              rstP,
  output logic              wdExpire
);
  localparam int CNT_W = BASE_W + $clog2(EXT_MULT);

  wdStrobe_t strobes;
  logic      expireHit;
  logic      rstActive;

  sup_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk       (clk),
    .supplyOk  (supplyOk),
    .holdTicks (holdTicks),
    .expireHit (expireHit),
    .strobes   (strobes),
    .rstActive (rstActive),
    .wdExpire  (wdExpire)
  );

  sup_datapath #(
    .BASE_W   (BASE_W),
    .EXT_MULT (EXT_MULT),
    .SELF_NUM (SELF_NUM)
  ) u_dp (
    .clk        (clk),
    .kickIn     (kickIn),
    .modeSel    (modeSel),
    .kickFloat  (kickFloat),
    .basePeriod (basePeriod),
    .strobes    (strobes),
    .expireHit  (expireHit)
  );

  assign rstN = !rstActive;
  assign rstP = rstActive;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int BASE_W = 16,
  parameter int CNT_W  = 25
) (
  input logic              clk,
  input logic              supplyOk,
  input logic              rstN,
  input logic              wdExpire,
  input logic [BASE_W-1:0] basePeriod,
  input logic [CNT_W-1:0]  wdCnt
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_low_supply_resets: assert property (@(posedge clk) disable iff (!armed)
    !supplyOk |-> !rstN);

  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!armed)
    $rose(rstN) |-> supplyOk);

  a_r3_expire_in_reset: assert property (@(posedge clk) disable iff (!armed)
    wdExpire |-> !rstN);

  a_r3_expire_single: assert property (@(posedge clk) disable iff (!armed)
    wdExpire |=> !wdExpire);

  a_r4_clear_in_reset: assert property (@(posedge clk) disable iff (!armed)
    !rstN |=> (wdCnt == '0));

  a_r10_off_no_expire: assert property (@(posedge clk) disable iff (!armed)
    ((basePeriod == '0) && $stable(basePeriod)) |=> !wdExpire);
endmodule

bind reset_supervisor sup_checker #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .supplyOk   (supplyOk),
  .rstN       (rstN),
  .wdExpire   (wdExpire),
  .basePeriod (basePeriod),
  .wdCnt      (u_dp.wdCnt)
);

// File: tb/sim_reset_supervisor.sv
`timescale 1ns/1ps
module sim_reset_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;
  localparam int BASE = 4;
  localparam int EXT  = BASE * 500;

  logic        clk = 1'b1;
  logic        supplyOk = 1'b1;
  logic        kickIn = 1'b0;
  logic        modeSel = 1'b0;
  logic        kickFloat = 1'b0;
  logic [15:0] holdTicks = 16'(HOLD);
  logic [15:0] basePeriod = '0;
  logic        rstN, rstP, wdExpire;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_supervisor u0 (
    .clk(clk), .supplyOk(supplyOk), .kickIn(kickIn), .modeSel(modeSel),
    .kickFloat(kickFloat), .holdTicks(holdTicks), .basePeriod(basePeriod),
    .rstN(rstN), .rstP(rstP), .wdExpire(wdExpire)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts consecutive negedge samples (current one included) where rstN == lvl.
  task automatic countLevel(input bit lvl, input int maxc, output int n);
    n = 0;
    while (rstN == lvl && n < maxc) begin
      if (rstP != !rstN) begin
        fails++;
        $display("FAIL R11: actual rstP %0d expected %0d", rstP, !rstN);
      end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testPowerOn();
    int n;
    @(negedge clk);
    check(rstN == 1'b0, "R12 initial rstN", rstN, 0);
    check(rstP == 1'b1, "R11 initial rstP", rstP, 1);
    check(wdExpire == 1'b0, "R12 initial wdExpire", wdExpire, 0);
    countLevel(1'b0, 100, n);
    check(n == HOLD, "R12 power-on hold length", n, HOLD);
  endtask

  task automatic testDisabled();
    int n;
    basePeriod = '0;
    countLevel(1'b1, 300, n);
    check(n == 300, "R10 zero base never expires", n, 300);
  endtask

  task automatic testBrownout();
    int n;
    supplyOk = 1'b0;
    #1;
    check(rstN == 1'b0, "R1 immediate assert", rstN, 0);
    check(rstP == 1'b1, "R11 inverse in brownout", rstP, 1);
    @(negedge clk);
    countLevel(1'b0, 8, n);
    check(n == 8, "R1 held while supply low", n, 8);
    supplyOk = 1'b1;
    countLevel(1'b0, 100, n);
    check(n == HOLD, "R2 hold after recovery", n, HOLD);
  endtask

  task automatic testNormalWatchdog();
    int n;
    basePeriod = 16'(BASE);
    countLevel(1'b1, 100, n);
    countLevel(1'b0, 100, n);
    for (int i = 0; i < 2; i++) begin
      countLevel(1'b1, 100, n);
      check(n == BASE, "R4 R7 normal timeout length", n, BASE);
      check(wdExpire == 1'b1, "R3 expire flag at pulse start", wdExpire, 1);
      @(negedge clk);
      check(wdExpire == 1'b0, "R3 expire flag one cycle", wdExpire, 0);
      countLevel(1'b0, 100, n);
      check(n == HOLD - 1, "R3 pulse length", n + 1, HOLD);
    end
  endtask

  task automatic testFloatNormal();
    int n;
    kickFloat = 1'b1;
    countLevel(1'b1, 100, n);
    check(n == BASE, "R9 floating ignored in normal mode", n, BASE);
    countLevel(1'b0, 100, n);
    countLevel(1'b1, 100, n);
    check(n == BASE, "R9 repeated pulses", n, BASE);
    countLevel(1'b0, 100, n);
    kickFloat = 1'b0;
  endtask

  task automatic testKicks();
    int n;
    int lowSeen = 0;
    for (int i = 0; i < 60; i++) begin
      if (i % 2 == 0) kickIn = !kickIn;
      if (rstN == 1'b0) lowSeen++;
      @(negedge clk);
    end
    check(lowSeen == 0, "R5 kicks hold off reset", lowSeen, 0);
    countLevel(1'b1, 100, n);
    check(n > 0 && n <= 6, "R5 expiry after kicks stop", n, BASE);
    countLevel(1'b0, 100, n);
    check(n == HOLD, "R3 pulse after kicks stop", n, HOLD);
  endtask

  task automatic testExtended();
    int n;
    countLevel(1'b1, 100, n);
    modeSel = 1'b1;
    countLevel(1'b0, 100, n);
    countLevel(1'b1, 3000, n);
    check(n == EXT, "R7 extended timeout length", n, EXT);
    countLevel(1'b0, 100, n);
    check(n == HOLD, "R7 pulse after extended timeout", n, HOLD);
  endtask

  task automatic testModeRestart();
    int n;
    countLevel(1'b1, EXT - 10, n);
    check(n == EXT - 10, "R6 still high before mode pulse", n, EXT - 10);
    modeSel = 1'b0;
    @(negedge clk);
    modeSel = 1'b1;
    @(negedge clk);
    countLevel(1'b1, 1900, n);
    check(n == 1900, "R6 mode change restarts count", n, 1900);
    countLevel(1'b1, 300, n);
    check(n > 0 && n < 300, "R6 expiry after restart", n, 110);
    countLevel(1'b0, 100, n);
  endtask

  task automatic testSelfKick();
    int n;
    kickFloat = 1'b1;
    countLevel(1'b1, 5000, n);
    check(n == 5000, "R8 self kick prevents expiry", n, 5000);
  endtask

  initial begin
    testPowerOn();
    testDisabled();
    testBrownout();
    testNormalWatchdog();
    testFloatNormal();
    testKicks();
    testExtended();
    testModeRestart();
    testSelfKick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule